// File: doc/BRIEF.md
# Monitor Configuration Port Register Bridge

This block connects a 32-bit processor register bus to the 16-bit dynamic-reconfiguration port (DRP) of an on-chip system monitor. A full-word read or write into the register window becomes one DRP transaction. The bridge issues a single-cycle enable with the address, the write flag and the write data, then waits for the port's ready strobe before it answers the bus. Read answers carry the 16-bit port word in the low half of the bus. Two JTAG status bits sit just above it: a sticky "modified by JTAG" flag and the live "locked by JTAG" level.

Some accesses are refused at once with an error response and never reach the port. These are partial-word strobes, addresses that are not word aligned, and any access while the JTAG side holds the lock. A successful port access clears the sticky modified flag. A one-cycle pulse from the JTAG side sets it again. Software reads converter results from the same word. A 10-bit result sits left-aligned in bits 15 to 6. The bridge passes all 16 bits through untouched, so masking the low 6 bits is left to the reader.

Top module: `drp_bridge`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid and drp_en are 0, and the sticky modified flag is clear, so the first successful read returns 0 in bit 16.
- R2: A request accepted with req_be = 4'b1111, req_addr[1:0] = 0 and jtag_locked = 0 raises drp_en for exactly one cycle, in the cycle after acceptance. In that cycle drp_addr = req_addr[8:2], drp_we equals req_write and drp_di equals req_wdata.
- R3: After an issued port access, rsp_valid stays 0 until drp_rdy is sampled high. rsp_valid is then 1 with rsp_err = 0 in the following cycle.
- R4: A successful read answers with rsp_rdata[15:0] equal to drp_do as sampled with drp_rdy, all 16 bits unmasked. rsp_rdata[16] holds the modified flag as it stood before completion. rsp_rdata[17] holds jtag_locked at the completion edge. rsp_rdata[31:18] is 0. A successful write answers with rsp_rdata = 0.
- R5: A request with req_be other than 4'b1111, or with req_addr[1:0] not 0, issues no drp_en. It answers in the next cycle with rsp_err = 1 and rsp_rdata = 0.
- R6: A request accepted while jtag_locked = 1 issues no drp_en. It answers in the next cycle with rsp_err = 1 and rsp_rdata = 0, and it leaves the modified flag unchanged.
- R7: A one-cycle jtag_mod_pulse sets the modified flag, and the flag holds until a successful port access completes, which clears it. A pulse in the completion cycle leaves the flag set.
- R8: Each accepted request gets exactly one single-cycle rsp_valid. req_ready is 0 from acceptance until the cycle after the response. Requests presented while req_ready is 0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Bus request present |
| req_ready | output | 1 | Bridge idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 9 | Byte address within the window |
| req_be | input | 4 | Byte strobes; all ones for a word access |
| req_wdata | input | 16 | Write data (low half of the bus) |
| rsp_valid | output | 1 | Response strobe, one cycle |
| rsp_err | output | 1 | 1 = error response, 0 = okay |
| rsp_rdata | output | 32 | Packed read word |
| drp_en | output | 1 | Port enable pulse |
| drp_we | output | 1 | Port write enable |
| drp_addr | output | 7 | Port register address |
| drp_di | output | 16 | Port write data |
| drp_do | input | 16 | Port read data |
| drp_rdy | input | 1 | Port completion strobe |
| jtag_locked | input | 1 | JTAG holds the port locked |
| jtag_mod_pulse | input | 1 | One-cycle pulse: JTAG changed port contents |

## Verification
The assertions assume that drp_rdy comes only while a port access is outstanding, as one pulse per enable. They also assume that jtag_mod_pulse is a clean single-cycle strobe. The bench's port model raises drp_rdy once per observed enable, after a random latency of zero to several cycles, and returns words from its own register image. It drives junk requests only while the bridge is busy, and it changes the lock level only between accesses or while an access is in flight.

// File: rtl/drp_bridge_pkg.sv
package drp_bridge_pkg;
  localparam int BUS_W = 32;
  localparam int PORT_DW = 16;
  localparam int FLAG_W = 2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RESP = 2'd2
  } bridge_state_e;
endpackage

// File: rtl/drp_bridge_decode.sv
module drp_bridge_decode #(
  parameter int ADDR_W = 9,
  parameter int PORT_AW = 7,
  parameter int BE_W = 4
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic [BE_W-1:0]    be,
  output logic               word_ok,
  output logic [PORT_AW-1:0] port_addr
);
  localparam int LSB_W = $clog2(BE_W);
  localparam int AVAIL = ADDR_W - LSB_W;

  assign word_ok = (&be) && (addr[LSB_W-1:0] == '0);

  generate
    if (AVAIL >= PORT_AW) begin : g_slice
      assign port_addr = addr[LSB_W +: PORT_AW];
    end else begin : g_pad
      assign port_addr = {{(PORT_AW-AVAIL){1'b0}}, addr[ADDR_W-1:LSB_W]};
    end
  endgenerate
endmodule

// File: rtl/drp_bridge_flag.sv
module drp_bridge_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_pulse,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst) flag <= 1'b0;
    else if (set_pulse) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end

  AST_MOD_SETS: assert property (@(posedge clk) disable iff (rst)
    set_pulse |=> flag); // R7
  AST_MOD_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (clr && !set_pulse) |=> !flag); // R7
  AST_MOD_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!clr && !set_pulse) |=> (flag == $past(flag))); // R7
endmodule

// File: rtl/drp_bridge_ctrl.sv
module drp_bridge_ctrl
  import drp_bridge_pkg::*;
#(
  parameter int PORT_AW = 7,
  parameter int DW = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [DW-1:0]      req_wdata,
  input  logic               word_ok,
  input  logic [PORT_AW-1:0] port_addr,
  input  logic               locked,
  input  logic               port_rdy,
  output logic               req_ready,
  output logic               port_en,
  output logic               port_we,
  output logic [PORT_AW-1:0] port_addr_q,
  output logic [DW-1:0]      port_di,
  output logic               rsp_valid,
  output logic               rsp_err,
  output logic               done_ok,
  output logic               refuse
);
  bridge_state_e state;
  logic accept;

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign refuse    = accept && (!word_ok || locked);
  assign done_ok   = (state == ST_WAIT) && port_rdy;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      port_en     <= 1'b0;
      port_we     <= 1'b0;
      port_addr_q <= '0;
      port_di     <= '0;
      rsp_valid   <= 1'b0;
      rsp_err     <= 1'b0;
    end else begin
      port_en   <= 1'b0;
      rsp_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (refuse) begin
            rsp_valid <= 1'b1;
            rsp_err   <= 1'b1;
            state     <= ST_RESP;
          end else if (accept) begin
            port_en     <= 1'b1;
            port_we     <= req_write;
            port_addr_q <= port_addr;
            port_di     <= req_wdata;
            state       <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (port_rdy) begin
            rsp_valid <= 1'b1;
            rsp_err   <= 1'b0;
            state     <= ST_RESP;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_EN_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    port_en |=> !port_en); // R2
  AST_EN_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    (accept && word_ok && !locked) |=> port_en); // R2
  AST_NO_RSP_WITH_EN: assert property (@(posedge clk) disable iff (rst)
    port_en |-> (!rsp_valid && !req_ready)); // R3
  AST_OK_NEEDS_RDY: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_err) |-> $past(port_rdy)); // R3
  AST_SUBWORD_REFUSED: assert property (@(posedge clk) disable iff (rst)
    (accept && !word_ok) |=> (!port_en && rsp_valid && rsp_err)); // R5
  AST_LOCK_REFUSED: assert property (@(posedge clk) disable iff (rst)
    (accept && locked) |=> (!port_en && rsp_valid && rsp_err)); // R6
  AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> (!rsp_valid && req_ready)); // R8
endmodule

// File: rtl/drp_bridge_pack.sv
module drp_bridge_pack
  import drp_bridge_pkg::*;
#(
  parameter int DW = 16,
  parameter int OUT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             keep_data,
  input  logic [DW-1:0]    port_do,
  input  logic             mod_flag,
  input  logic             locked,
  output logic [OUT_W-1:0] rdata
);
  localparam int PAD_W = OUT_W - DW - FLAG_W;

  logic [OUT_W-1:0] packed_word;

  generate
    if (PAD_W > 0) begin : g_pad
      assign packed_word = {{PAD_W{1'b0}}, locked, mod_flag, port_do};
    end else begin : g_nopad
      assign packed_word = {locked, mod_flag, port_do};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (load) rdata <= keep_data ? packed_word : '0;
  end
endmodule

// File: rtl/drp_bridge.sv
module drp_bridge
  import drp_bridge_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int PORT_AW = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [3:0]         req_be,
  input  logic [PORT_DW-1:0] req_wdata,
  output logic               rsp_valid,
  output logic               rsp_err,
  output logic [BUS_W-1:0]   rsp_rdata,
  output logic               drp_en,
  output logic               drp_we,
  output logic [PORT_AW-1:0] drp_addr,
  output logic [PORT_DW-1:0] drp_di,
  input  logic [PORT_DW-1:0] drp_do,
  input  logic               drp_rdy,
  input  logic               jtag_locked,
  input  logic               jtag_mod_pulse
);
  logic               word_ok;
  logic [PORT_AW-1:0] dec_addr;
  logic               done_ok;
  logic               refuse;
  logic               mod_flag;

  drp_bridge_decode #(.ADDR_W(ADDR_W), .PORT_AW(PORT_AW), .BE_W(4)) u_decode (
    .addr(req_addr), .be(req_be), .word_ok(word_ok), .port_addr(dec_addr)
  );

  drp_bridge_ctrl #(.PORT_AW(PORT_AW), .DW(PORT_DW)) u_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_wdata(req_wdata), .word_ok(word_ok), .port_addr(dec_addr),
    .locked(jtag_locked), .port_rdy(drp_rdy), .req_ready(req_ready),
    .port_en(drp_en), .port_we(drp_we), .port_addr_q(drp_addr),
    .port_di(drp_di), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
    .done_ok(done_ok), .refuse(refuse)
  );

  drp_bridge_flag u_flag (
    .clk(clk), .rst(rst), .set_pulse(jtag_mod_pulse), .clr(done_ok), .flag(mod_flag)
  );

  drp_bridge_pack #(.DW(PORT_DW), .OUT_W(BUS_W)) u_pack (
    .clk(clk), .rst(rst), .load(done_ok || refuse), .keep_data(done_ok && !drp_we),
    .port_do(drp_do), .mod_flag(mod_flag), .locked(jtag_locked), .rdata(rsp_rdata)
  );

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_rdata[BUS_W-1:PORT_DW+FLAG_W] == '0)); // R4
  AST_ERR_DATA_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_err) |-> (rsp_rdata == '0)); // R5
endmodule

// File: tb/drp_bridge_tb.sv
module drp_bridge_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [8:0]  req_addr = '0;
  logic [3:0]  req_be = '0;
  logic [15:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_err;
  logic [31:0] rsp_rdata;
  logic        drp_en;
  logic        drp_we;
  logic [6:0]  drp_addr;
  logic [15:0] drp_di;
  logic [15:0] drp_do = '0;
  logic        drp_rdy = 1'b0;
  logic        jtag_locked = 1'b0;
  logic        jtag_mod_pulse = 1'b0;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  bit exp_mod = 1'b0;
  logic [15:0] image [128];

  always #2 clk = ~clk;

  drp_bridge u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_be(req_be),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
    .rsp_rdata(rsp_rdata), .drp_en(drp_en), .drp_we(drp_we),
    .drp_addr(drp_addr), .drp_di(drp_di), .drp_do(drp_do), .drp_rdy(drp_rdy),
    .jtag_locked(jtag_locked), .jtag_mod_pulse(jtag_mod_pulse)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] read_word(input bit lk, input bit md, input logic [15:0] d);
    return {14'b0, lk, md, d};
  endfunction

  function automatic bit refused(input logic [8:0] a, input logic [3:0] be, input bit lk);
    return (be != 4'hF) || (a[1:0] != 2'b00) || lk;
  endfunction

  task automatic pulse_mod();
    @(negedge clk); jtag_mod_pulse = 1'b1;
    @(negedge clk); jtag_mod_pulse = 1'b0;
    exp_mod = 1'b1;
  endtask

  task automatic access(input bit wr, input logic [8:0] a, input logic [3:0] be,
                        input logic [15:0] wd, input int lat, input bit lk,
                        input bit lk_mid, input bit pulse_done);
    logic [31:0] exp_rd;
    @(negedge clk);
    jtag_locked = lk; req_valid = 1'b1; req_write = wr; req_addr = a; req_be = be; req_wdata = wd;
    check("R8 ready before accept", {31'b0, req_ready}, 32'd1);
    @(negedge clk);
    req_valid = 1'b0;
    if (refused(a, be, lk)) begin
      if (lk) check("R6 locked: no enable", {31'b0, drp_en}, 32'd0);
      else    check("R5 subword: no enable", {31'b0, drp_en}, 32'd0);
      check(lk ? "R6 err response" : "R5 err response", {30'b0, rsp_valid, rsp_err}, 32'd3);
      check("R5 err data zero", rsp_rdata, 32'd0);
    end else begin
      check("R2 enable pulse", {31'b0, drp_en}, 32'd1);
      check("R2 addr", {25'b0, drp_addr}, {25'b0, a[8:2]});
      check("R2 we", {31'b0, drp_we}, {31'b0, wr});
      if (wr) begin
        check("R2 di", {16'b0, drp_di}, {16'b0, wd});
        image[a[8:2]] = wd;
      end
      if (lk_mid) jtag_locked = 1'b1;
      for (int i = 0; i < lat; i++) begin
        req_valid = 1'b1; req_addr = 9'h1F0; req_write = 1'b1; req_be = 4'hF;
        @(negedge clk);
        check("R3 no response while waiting", {30'b0, rsp_valid, drp_en}, 32'd0);
      end
      req_valid = 1'b0;
      drp_rdy = 1'b1; drp_do = image[a[8:2]];
      if (pulse_done) jtag_mod_pulse = 1'b1;
      exp_rd = wr ? 32'd0 : read_word(lk_mid, exp_mod, image[a[8:2]]);
      @(negedge clk);
      drp_rdy = 1'b0; jtag_mod_pulse = 1'b0; drp_do = 16'hDEAD;
      check("R3 ok response", {30'b0, rsp_valid, rsp_err}, 32'd2);
      check(wr ? "R4 write data zero" : "R4 read word", rsp_rdata, exp_rd);
      check("R8 busy during response", {31'b0, req_ready}, 32'd0);
      exp_mod = pulse_done;
    end
    @(negedge clk);
    check("R8 single response", {30'b0, rsp_valid, req_ready}, 32'd1);
    jtag_locked = 1'b0;
  endtask

  initial begin : watchdog
    for (int c = 0; c < 100000; c++) begin
      @(posedge clk);
      if (finished) disable watchdog;
    end
    bad++; total++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit wr, lk, lkm, pd;
    logic [8:0] a;
    logic [3:0] be;
    void'($urandom(32'd1234));
    for (int i = 0; i < 128; i++) image[i] = 16'(i * 16'h0101 + 16'h5A);
    repeat (3) @(negedge clk);
    check("R1 reset outputs", {29'b0, req_ready, rsp_valid, drp_en}, 32'd4);
    rst = 1'b0;
    @(negedge clk);
    check("R1 idle after reset", {29'b0, req_ready, rsp_valid, drp_en}, 32'd4);
    access(1'b0, 9'h010, 4'hF, 16'h0, 0, 1'b0, 1'b0, 1'b0);   // R1 flag clear
    pulse_mod();
    access(1'b0, 9'h014, 4'hF, 16'h0, 2, 1'b0, 1'b0, 1'b0);   // R7 set, then cleared
    access(1'b0, 9'h014, 4'hF, 16'h0, 1, 1'b0, 1'b0, 1'b0);   // R7 now clear
    pulse_mod();
    access(1'b1, 9'h020, 4'hF, 16'hBEEF, 0, 1'b1, 1'b0, 1'b0); // R6 locked write
    access(1'b0, 9'h020, 4'hF, 16'h0, 0, 1'b0, 1'b0, 1'b0);   // R6 flag kept, write not done
    access(1'b0, 9'h030, 4'b0011, 16'h0, 0, 1'b0, 1'b0, 1'b0); // R5 half word
    access(1'b1, 9'h031, 4'hF, 16'h1234, 0, 1'b0, 1'b0, 1'b0); // R5 misaligned
    access(1'b1, 9'h040, 4'hF, 16'hFFC0, 5, 1'b0, 1'b0, 1'b0); // R2 long wait
    access(1'b0, 9'h040, 4'hF, 16'h0, 3, 1'b0, 1'b1, 1'b0);   // R4 locked bit mid-access
    access(1'b1, 9'h044, 4'hF, 16'h003F, 0, 1'b0, 1'b0, 1'b1); // R7 pulse at completion
    access(1'b0, 9'h044, 4'hF, 16'h0, 0, 1'b0, 1'b0, 1'b0);   // R4 low bits unmasked
    for (int n = 0; n < 80; n++) begin
      wr = 1'($urandom % 2);
      a = {$urandom % 128, 2'b00};
      if ($urandom % 10 == 0) a[1:0] = 2'($urandom % 4);
      be = ($urandom % 6 == 0) ? 4'($urandom % 16) : 4'hF;
      lk = ($urandom % 8 == 0);
      lkm = ($urandom % 8 == 0);
      pd = ($urandom % 6 == 0);
      if ($urandom % 4 == 0) pulse_mod();
      access(wr, a, be, 16'($urandom), int'($urandom % 4), lk, lkm, pd);
    end
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule